// File: doc/BRIEF.md
# Change-of-State Digital Input Port

This block samples forty-eight digital input lines, arranged as six byte-wide groups, and makes them readable on a simple byte-wide I/O bus through an eight-byte address window. Each group can latch a change-of-state event whenever any of its lines toggles, whether rising or falling, provided the group has been enabled. A level interrupt request is asserted while any event remains latched.

The upper location of the window holds two registers. A write to it loads the per-group enables. A read returns the latched group flags and an active-low pending bit, then clears the flags. Because the pending bit shows whether this device raised the request, the request can be wired onto an interrupt line shared with other sources.

Top module: `cos_input_port`

## Requirements
- R1: Groups 0, 1 and 2 read at offsets 0, 1 and 2, and groups 3, 4 and 5 at offsets 4, 5 and 6. Input line k appears in bit k mod 8 of group k/8. A change on a pin is visible on a read two clock edges after it is applied.
- R2: A read of offset 3 returns 0x00. Bit 7 of the status read at offset 7 is always 0.
- R3: A write to offset 7 loads the enables. Data bit n (n = 0..5) enables group n, and data bits 6 and 7 are ignored.
- R4: A rising or a falling transition on any line of an enabled group sets status bit n for that group. Several groups can be flagged at once.
- R5: Transitions on lines of a disabled group set no flag and raise no interrupt.
- R6: Status bit 6 reads 0 while any group flag is set and reads 1 otherwise. irqOut is high exactly while any group flag is set.
- R7: A read of offset 7 returns the current status. The group flags are then cleared, and irqOut falls unless a new event arrives.
- R8: A change detected in the same cycle as a status read is latched after the clear and is not lost.
- R9: Clearing a group's enable clears that group's pending flag. Writing 0x00 to offset 7 disables every group and drops irqOut.
- R10: Writes to offsets 0 to 6 have no effect: the enables and the flags keep their values.
- R11: After reset the enables and flags are zero, irqOut is low, and offset 7 reads 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Byte offset within the window |
| busWrEn | input | 1 | Write strobe, one cycle per access |
| busRdEn | input | 1 | Read strobe, one cycle per access |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from busAddr |
| inPins | input | 48 | Asynchronous input lines |
| irqOut | output | 1 | Level interrupt request, active high |

## Verification
A flag latched for the wrong group, or latched while the group is disabled, shows in the status byte and on irqOut three edges after the pin toggle. A clear that swallows a simultaneous event shows as a missing bit on the very next status read. A corrupted enable register shows only when a later toggle does or does not raise irqOut, so each enable case is followed by a deliberate toggle. Mapping errors in the group offsets show on a direct read two edges after the pins change.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int GROUP_W    = 8;
  localparam int NUM_GROUPS = 6;
  localparam int ADDR_W     = 3;
  localparam int PIN_W      = GROUP_W * NUM_GROUPS;
  localparam int CTRL_ADDR  = 7;
  localparam int RSV_ADDR   = 3;
  localparam int PEND_BIT   = 6;

  // control-to-datapath strobes
  typedef struct packed {
    logic                  enLoad;
    logic                  statClr;
    logic [NUM_GROUPS-1:0] enMask;
    logic [NUM_GROUPS-1:0] enNext;
  } cosStrobe_t;

  // groups below the reserved hole sit at their own index, the rest one above
  function automatic int groupOffset(input int g);
    return (g < RSV_ADDR) ? g : g + 1;
  endfunction
endpackage

// File: rtl/cos_ctrl.sv
module cos_ctrl
  import cos_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [GROUP_W-1:0] busWrData,
  output cosStrobe_t        strobe
);
  logic [NUM_GROUPS-1:0] enReg;
  logic                  ctrlHit;
  logic                  enLoad;

  assign ctrlHit = (busAddr == ADDR_W'(CTRL_ADDR));
  assign enLoad  = busWrEn && ctrlHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enReg <= '0;
    else if (enLoad) enReg <= busWrData[NUM_GROUPS-1:0];
  end

  always_comb begin
    strobe.enLoad  = enLoad;
    strobe.statClr = busRdEn && ctrlHit;
    strobe.enMask  = enReg;
    strobe.enNext  = enLoad ? busWrData[NUM_GROUPS-1:0] : enReg;
  end
endmodule

// File: rtl/cos_datapath.sv
module cos_datapath
  import cos_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PIN_W-1:0]      inPins,
  input  logic [ADDR_W-1:0]     busAddr,
  input  cosStrobe_t            strobe,
  output logic [GROUP_W-1:0]    busRdData,
  output logic                  irqOut,
  output logic [NUM_GROUPS-1:0] groupFlags,
  output logic [NUM_GROUPS-1:0] groupChange
);
  logic [PIN_W-1:0]      syncA;
  logic [PIN_W-1:0]      syncB;
  logic [PIN_W-1:0]      prevVal;
  logic [NUM_GROUPS-1:0] flagsNext;
  logic [GROUP_W-1:0]    statusByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      prevVal <= '0;
    end else begin
      syncA   <= inPins;
      syncB   <= syncA;
      prevVal <= syncB;
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gChange
    assign groupChange[g] =
      |(syncB[g*GROUP_W +: GROUP_W] ^ prevVal[g*GROUP_W +: GROUP_W]);
  end

  assign flagsNext = ((groupFlags & ~{NUM_GROUPS{strobe.statClr}})
                      | (groupChange & strobe.enMask)) & strobe.enNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) groupFlags <= '0;
    else       groupFlags <= flagsNext;
  end

  assign irqOut = |groupFlags;

  always_comb begin
    statusByte = '0;
    statusByte[NUM_GROUPS-1:0] = groupFlags;
    statusByte[PEND_BIT] = ~irqOut;
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(CTRL_ADDR)) busRdData = statusByte;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (busAddr == ADDR_W'(groupOffset(g)))
        busRdData = syncB[g*GROUP_W +: GROUP_W];
    end
  end
endmodule

// File: rtl/cos_input_port.sv
module cos_input_port
  import cos_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  busAddr,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [7:0]  busWrData,
  output logic [7:0]  busRdData,
  input  logic [47:0] inPins,
  output logic        irqOut
);
  cosStrobe_t            strobe;
  logic [NUM_GROUPS-1:0] groupFlags;
  logic [NUM_GROUPS-1:0] groupChange;
  logic [NUM_GROUPS-1:0] enMask;

  assign enMask = strobe.enMask;

  cos_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busWrData (busWrData),
    .strobe    (strobe)
  );

  cos_datapath i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .inPins      (inPins),
    .busAddr     (busAddr),
    .strobe      (strobe),
    .busRdData   (busRdData),
    .irqOut      (irqOut),
    .groupFlags  (groupFlags),
    .groupChange (groupChange)
  );
endmodule

// File: rtl/cos_checker.sv
module cos_checker
  import cos_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic [2:0]            busAddr,
  input logic                  busWrEn,
  input logic                  busRdEn,
  input logic [7:0]            busRdData,
  input logic                  irqOut,
  input logic [NUM_GROUPS-1:0] groupFlags,
  input logic [NUM_GROUPS-1:0] groupChange,
  input logic [NUM_GROUPS-1:0] enMask
);
  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 3'd3) |-> (busRdData == 8'h00));

  // R2
  stat_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 3'd7) |-> !busRdData[7]);

  // R4
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((groupFlags & ~$past(groupFlags)) != '0) |->
      ($past(groupChange & enMask) != '0));

  // R9
  flag_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (groupFlags & ~enMask) == '0);

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == 3'd7 && groupChange == '0) |=> (groupFlags == '0));

  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past((busRdEn || busWrEn) && busAddr == 3'd7));

  // R10
  en_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == 3'd7) |=> (enMask == $past(enMask)));
endmodule

bind cos_input_port cos_checker i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busAddr     (busAddr),
  .busWrEn     (busWrEn),
  .busRdEn     (busRdEn),
  .busRdData   (busRdData),
  .irqOut      (irqOut),
  .groupFlags  (groupFlags),
  .groupChange (groupChange),
  .enMask      (enMask)
);

// File: tb/test_cos_input_port.sv
`timescale 1ns/1ps
module test_cos_input_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [47:0] inPins = '0;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cos_input_port i_cos_input_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .inPins(inPins), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  // apply pins and wait until a resulting flag would be latched
  task automatic setPins(input logic [47:0] v);
    @(negedge clk);
    inPins = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d;
    chk("R11 irq", {7'd0, irqOut}, 8'h00);
    busRead(3'd7, d);
    chk("R11 status", d, 8'h40);
  endtask

  task automatic testGroupRead();
    logic [7:0] d;
    logic [47:0] pat = 48'hA5_3C_96_0F_F0_81;
    setPins(pat);
    for (int g = 0; g < 6; g++) begin
      busRead((g < 3) ? 3'(g) : 3'(g + 1), d);
      chk("R1 group read", d, pat[g*8 +: 8]);
    end
    chk("R5 no irq while disabled", {7'd0, irqOut}, 8'h00);
  endtask

  task automatic testReserved();
    logic [7:0] d;
    busRead(3'd3, d);
    chk("R2 offset 3", d, 8'h00);
  endtask

  task automatic testEdges();
    logic [7:0] d;
    busWrite(3'd7, 8'hFF);
    setPins(inPins ^ (48'h1 << 13));
    chk("R6 irq high", {7'd0, irqOut}, 8'h01);
    busRead(3'd7, d);
    chk("R4 toggle group1", d, 8'h02);
    setPins(inPins ^ (48'h1 << 13));
    busRead(3'd7, d);
    chk("R4 reverse toggle group1", d, 8'h02);
    setPins(inPins ^ (48'h1 << 47));
    busRead(3'd7, d);
    chk("R4 group5", d, 8'h20);
    setPins(inPins ^ ((48'h1 << 0) | (48'h1 << 40)));
    busRead(3'd7, d);
    chk("R4 two groups", d, 8'h21);
    chk("R7 irq cleared", {7'd0, irqOut}, 8'h00);
    busRead(3'd7, d);
    chk("R6 idle status", d, 8'h40);
  endtask

  task automatic testDisabledGroup();
    logic [7:0] d;
    busWrite(3'd7, 8'h01);
    setPins(inPins ^ (48'h1 << 20));
    chk("R5 disabled irq", {7'd0, irqOut}, 8'h00);
    busRead(3'd7, d);
    chk("R5 disabled status", d, 8'h40);
    setPins(inPins ^ (48'h1 << 3));
    busRead(3'd7, d);
    chk("R3 enabled group0", d, 8'h01);
  endtask

  task automatic testClearRace();
    logic [7:0] d;
    busWrite(3'd7, 8'h03);
    setPins(inPins ^ 48'h1);
    @(negedge clk);
    inPins = inPins ^ (48'h1 << 8);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    busAddr = 3'd7; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
    chk("R7 status before clear", d, 8'h01);
    chk("R8 irq kept", {7'd0, irqOut}, 8'h01);
    busRead(3'd7, d);
    chk("R8 racing event kept", d, 8'h02);
  endtask

  task automatic testDisable();
    logic [7:0] d;
    busWrite(3'd7, 8'h03);
    setPins(inPins ^ ((48'h1 << 1) | (48'h1 << 9)));
    chk("R6 pending", {7'd0, irqOut}, 8'h01);
    busWrite(3'd7, 8'h02);
    busWrite(3'd1, 8'h00);
    busRead(3'd7, d);
    chk("R9 group0 flag dropped", d, 8'h02);
    setPins(inPins ^ (48'h1 << 9));
    busWrite(3'd7, 8'h00);
    chk("R9 irq dropped", {7'd0, irqOut}, 8'h00);
    busRead(3'd7, d);
    chk("R9 all off", d, 8'h40);
  endtask

  task automatic testIgnoredWrites();
    logic [7:0] d;
    busWrite(3'd7, 8'hC4);
    for (int a = 0; a < 7; a++) busWrite(3'(a), 8'hFF);
    setPins(inPins ^ (48'h1 << 17));
    chk("R10 irq via group2", {7'd0, irqOut}, 8'h01);
    busRead(3'd7, d);
    chk("R3 upper bits ignored", d, 8'h04);
    for (int a = 0; a < 7; a++) busWrite(3'(a), 8'h00);
    setPins(inPins ^ (48'h1 << 17) ^ (48'h1 << 30));
    busRead(3'd7, d);
    chk("R10 enables kept", d, 8'h04);
    busRead(3'd2, d);
    chk("R10 pins still readable", d, inPins[16 +: 8]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGroupRead();
    testReserved();
    testEdges();
    testDisabledGroup();
    testClearRace();
    testDisable();
    testIgnoredWrites();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule